// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Commit Timer

This block sits behind the serial front end of a small nonvolatile memory. It collects the data bytes of one write transaction in a 16-entry page buffer and commits them to a 2048 x 8 memory array. The front end does the bit-level protocol and sends single-cycle strobes: transaction start, address loaded, data byte, stop and abort. Each data byte goes to the buffer slot named by the low four bits of a running offset. The offset starts at the low bits of the supplied address. It advances after every byte and wraps inside the page.

A stop that follows at least one buffered byte starts a timed write cycle. The commit can be blocked in two ways. Write protect may have been high at any point since the transaction started, or the low-supply flag may be set when the stop arrives. During the write cycle the block holds busy high for a fixed number of clocks. In the first sixteen of those clocks it walks the buffer and writes each loaded slot through the memory write port. While busy it accepts no strobes. The block also reports the current address that a following read would use.

Top module: `eeprom_page_committer`

## Requirements
- R1: After reset, busy, the write enable and the current address (0) are all low.
- R2: A byte accepted as the k-th data byte after an address A is committed to address {A[10:4], (A[3:0]+k) mod 16}. All writes of one commit fall in the page of A.
- R3: When more than 16 bytes arrive, the offset wraps inside the page and a later byte overwrites the earlier value in the same slot. Only the last value of each slot is written.
- R4: A commit writes only the slots loaded in this transaction, once each. Every other location of the page keeps its previous contents.
- R5: A stop with no buffered data byte starts no write cycle. Busy stays low and no write is issued.
- R6: The write cycle starts in the cycle after the accepted stop and keeps busy high for exactly WRITE_CLKS cycles. Start, byte and stop strobes during that time have no effect on memory contents or on the current address.
- R7: If write protect is high in any cycle from the start strobe through the stop strobe, the stop starts no write cycle and writes nothing.
- R8: If the low-supply flag is high in the stop cycle, the stop starts no write cycle and writes nothing.
- R9: After a transaction of 1 to 16 bytes, the current address is {A[10:4], (A[3:0]+n) mod 16}. After more than 16 bytes, it is the supplied address A.
- R10: A start or abort strobe before the stop discards all buffered bytes. A later stop writes only bytes loaded after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction start strobe |
| abort_i | input | 1 | Transaction aborted strobe |
| addr_vld_i | input | 1 | Memory address strobe |
| addr_i | input | 11 | Memory address supplied by the front end |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Transaction stop strobe |
| wp_i | input | 1 | Write protect, high blocks the commit |
| lowv_i | input | 1 | Supply below write threshold |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 11 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| cur_addr_o | output | 11 | Current address left for a following read |

## Verification
On every cycle, the assertions check four things. A write cycle can begin only right after a stop that saw neither write protect nor low supply. Writes appear only while busy. The page of the write address and the current address stay fixed through a busy period. Other behaviour shows only in the bench's scenarios: which slots are written and with which values under wrapping, the exact busy length, and the current address left after short and over-long pages. The same holds for the discarding of buffers by start and abort, and for blocking by write protect raised only briefly. A sweep over every start offset and byte counts from 1 to 20 checks these against a reference memory.

// File: rtl/eeprom_page_committer.sv
module eeprom_page_committer #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int WRITE_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              lowv_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int TW   = $clog2(WRITE_CLKS) + 1;

  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   vmask;
  logic [ADDR_W-1:0] base;
  logic [PAGE_W-1:0] ptr;
  logic [PAGE_W:0]   cnt;
  logic              ovf, wp_seen, busy;
  logic [TW-1:0]     tmr;

  wire clr_txn   = !busy && (start_i || abort_i);
  wire take_addr = !busy && !clr_txn && addr_vld_i;
  wire take_byte = !busy && !clr_txn && !addr_vld_i && byte_vld_i;
  wire take_stop = !busy && !clr_txn && !addr_vld_i && !byte_vld_i && stop_i;
  wire blocked   = wp_seen || wp_i || lowv_i;
  wire go        = take_stop && (|vmask) && !blocked;

  wire [PAGE_W-1:0] idx = tmr[PAGE_W-1:0];

  assign busy_o      = busy;
  assign mem_we_o    = busy && (tmr < TW'(PAGE)) && vmask[idx];
  assign mem_addr_o  = {base[ADDR_W-1:PAGE_W], idx};
  assign mem_wdata_o = pbuf[idx];
  assign cur_addr_o  = ovf ? base : {base[ADDR_W-1:PAGE_W], ptr};

  always_ff @(posedge clk) begin
    if (take_byte) pbuf[ptr] <= byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask   <= '0;
      base    <= '0;
      ptr     <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
      wp_seen <= 1'b0;
      busy    <= 1'b0;
      tmr     <= '0;
    end else if (busy) begin
      tmr <= tmr + 1'b1;
      if (tmr == TW'(WRITE_CLKS - 1)) begin
        busy  <= 1'b0;
        vmask <= '0;
      end
    end else begin
      wp_seen <= wp_seen | wp_i;
      if (clr_txn) begin
        vmask   <= '0;
        cnt     <= '0;
        wp_seen <= start_i & wp_i;
      end else if (take_addr) begin
        base  <= addr_i;
        ptr   <= addr_i[PAGE_W-1:0];
        vmask <= '0;
        cnt   <= '0;
        ovf   <= 1'b0;
      end else if (take_byte) begin
        vmask[ptr] <= 1'b1;
        ptr        <= ptr + 1'b1;
        if (cnt == (PAGE_W+1)'(PAGE)) ovf <= 1'b1;
        else                          cnt <= cnt + 1'b1;
      end else if (take_stop) begin
        wp_seen <= 1'b0;
        cnt     <= '0;
        if (go) begin
          busy <= 1'b1;
          tmr  <= '0;
        end else begin
          vmask <= '0;
        end
      end
    end
  end

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
  a_r7_no_commit_wp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));
  a_r8_no_commit_lowv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(lowv_i));
  a_r4_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));
endmodule

// File: tb/eeprom_page_committer_test.sv
module eeprom_page_committer_test;
  localparam int WCLK = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, abort_i = 0, addr_vld_i = 0, byte_vld_i = 0, stop_i = 0;
  logic wp_i = 0, lowv_i = 0;
  logic [10:0] addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic        busy_o, mem_we_o;
  logic [10:0] mem_addr_o, cur_addr_o;
  logic [7:0]  mem_wdata_o;

  eeprom_page_committer #(.ADDR_W(11), .PAGE_W(4), .WRITE_CLKS(WCLK)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i), .lowv_i(lowv_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .cur_addr_o(cur_addr_o));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mem [2048];
  logic [7:0] expm [2048];
  int blen, wcnt;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic st, ab, av, bv, sp, input logic [10:0] a, input logic [7:0] d);
    start_i = st; abort_i = ab; addr_vld_i = av; byte_vld_i = bv; stop_i = sp;
    addr_i = a; byte_i = d;
    @(negedge clk);
    start_i = 0; abort_i = 0; addr_vld_i = 0; byte_vld_i = 0; stop_i = 0;
  endtask

  task automatic run_commit(input bit poke);
    blen = 0; wcnt = 0;
    while (busy_o && blen < 1000) begin
      if (mem_we_o) begin
        wcnt++;
        mem[mem_addr_o] = mem_wdata_o;
      end
      if (poke && blen == 17) begin
        start_i = 1; byte_vld_i = 1; stop_i = 1; byte_i = 8'h5A;
      end else begin
        start_i = 0; byte_vld_i = 0; stop_i = 0;
      end
      blen++;
      @(negedge clk);
    end
    start_i = 0; byte_vld_i = 0; stop_i = 0;
  endtask

  task automatic quiet(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (busy_o || mem_we_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic page_cmp(input string req, input logic [6:0] pg);
    int miss = 0, ga = 0, ea = 0;
    for (int i = 0; i < 16; i++) begin
      if (mem[{pg, 4'(i)}] !== expm[{pg, 4'(i)}]) begin
        if (miss == 0) begin ga = mem[{pg, 4'(i)}]; ea = expm[{pg, 4'(i)}]; end
        miss++;
      end
    end
    chk(miss == 0, req, ga, ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] pg;
    logic [3:0] of;
    logic [7:0] d;
    int n;
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'hFF; expm[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && mem_we_o == 0, "R1 reset busy/we", {busy_o, mem_we_o}, 0);
    chk(cur_addr_o == 0, "R1 reset cur_addr", cur_addr_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R6 R9 sweep over offset and length
    for (int t = 0; t < 320; t++) begin
      of = 4'(t % 16);
      n  = t / 16 + 1;
      pg = 7'((t * 37) % 128);
      step(1, 0, 0, 0, 0, '0, '0);
      step(0, 0, 1, 0, 0, {pg, of}, '0);
      for (int k = 0; k < n; k++) begin
        d = 8'((t * 7 + k * 13 + 1) & 255);
        expm[{pg, 4'((of + k) % 16)}] = d;
        step(0, 0, 0, 1, 0, '0, d);
      end
      step(0, 0, 0, 0, 1, '0, '0);
      run_commit(0);
      chk(blen == WCLK, "R6 busy length", blen, WCLK);
      chk(wcnt == (n > 16 ? 16 : n), "R4 write count", wcnt, n > 16 ? 16 : n);
      page_cmp(n > 16 ? "R3 wrapped page" : "R2 page content", pg);
      if (n > 16) chk(cur_addr_o == {pg, of}, "R9 cur_addr long", cur_addr_o, {pg, of});
      else chk(cur_addr_o == {pg, 4'((of + n) % 16)}, "R9 cur_addr short",
               cur_addr_o, {pg, 4'((of + n) % 16)});
    end

    // R5 stop without data
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h123, '0);
    step(0, 0, 0, 0, 1, '0, '0);
    quiet("R5 empty stop", 30);
    chk(cur_addr_o == 11'h123, "R5 cur_addr set by address", cur_addr_o, 11'h123);

    // R7 write protect high only briefly inside transaction
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h200, '0);
    wp_i = 1;
    step(0, 0, 0, 1, 0, '0, 8'h11);
    wp_i = 0;
    step(0, 0, 0, 1, 0, '0, 8'h22);
    step(0, 0, 0, 0, 1, '0, '0);
    quiet("R7 protected commit", 30);
    page_cmp("R7 memory untouched", 7'h20);
    // R7 protect high at start only
    wp_i = 1;
    step(1, 0, 0, 0, 0, '0, '0);
    wp_i = 0;
    step(0, 0, 1, 0, 0, 11'h200, '0);
    step(0, 0, 0, 1, 0, '0, 8'h33);
    step(0, 0, 0, 0, 1, '0, '0);
    quiet("R7 protect at start", 30);

    // R8 low supply at stop
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h345, '0);
    step(0, 0, 0, 1, 0, '0, 8'h44);
    lowv_i = 1;
    step(0, 0, 0, 0, 1, '0, '0);
    lowv_i = 0;
    quiet("R8 low supply", 30);
    page_cmp("R8 memory untouched", 7'h34);

    // R10 restart discards
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h400, '0);
    step(0, 0, 0, 1, 0, '0, 8'h55);
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 0, 0, 1, '0, '0);
    quiet("R10 start discards", 30);
    // R10 abort then new data: only new byte written
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h400, '0);
    step(0, 0, 0, 1, 0, '0, 8'h66);
    step(0, 1, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h405, '0);
    step(0, 0, 0, 1, 0, '0, 8'h77);
    expm[11'h405] = 8'h77;
    step(0, 0, 0, 0, 1, '0, '0);
    run_commit(0);
    chk(wcnt == 1, "R10 abort writes only new byte", wcnt, 1);
    page_cmp("R10 page after abort", 7'h40);

    // R6 strobes during busy ignored
    step(1, 0, 0, 0, 0, '0, '0);
    step(0, 0, 1, 0, 0, 11'h50E, '0);
    step(0, 0, 0, 1, 0, '0, 8'h88);
    step(0, 0, 0, 1, 0, '0, 8'h99);
    expm[11'h50E] = 8'h88; expm[11'h50F] = 8'h99;
    step(0, 0, 0, 0, 1, '0, '0);
    run_commit(1);
    chk(blen == WCLK, "R6 busy length with strobes", blen, WCLK);
    chk(cur_addr_o == 11'h500, "R6 cur_addr unchanged", cur_addr_o, 11'h500);
    quiet("R6 no retrigger", 30);
    page_cmp("R6 page unchanged by strobes", 7'h50);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule